// File: doc/BRIEF.md
# Asynchronous EPROM Read Sequencer

This block connects a synchronous host to a 4096-word by 8-bit asynchronous parallel EPROM. The host hands over a 12-bit address on a valid/ready request channel. The block then drives the address and pulls chip-enable low. It pulls output-enable low later, once the output-enable path is no longer the slowest one. It samples the data bus after every access time has run out and returns the byte on a valid/ready response channel. It then releases both enables and waits for the memory outputs to float before it takes the next request.

All wait lengths are worked out during elaboration from two parameters: the clock frequency in MHz and the speed grade of the part, which is its address access time of 150, 200 or 250 ns. Each time is turned into cycles as ceil(ns × MHz / 1000) plus one margin cycle. Chip-enable access is the same as address access. The output-enable delay after chip-enable is the address-access count minus the output-enable count, but never less than one cycle, so a late output-enable does not lengthen the access. While no access is in progress, both enables stay high and the memory sits in standby.

Back-pressure works as follows. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only when the sequencer is idle and no response is waiting. A response stays valid, with its data unchanged, until an edge where `rsp_ready` is high. A request that arrives during an access or during the float wait simply waits.

Top module: `eprom_rd_ctrl`

## Requirements
- R1: After reset, `mem_ce_n` and `mem_oe_n` are 1, `rsp_valid` is 0 and `req_ready` is 1.
- R2: On the edge that accepts a request, `mem_addr` takes `req_addr` and `mem_ce_n` goes to 0. `mem_addr` stays unchanged for as long as `mem_ce_n` is 0.
- R3: `mem_oe_n` falls exactly D_OE = max(1, N_ACC − N_OE) cycles after `mem_ce_n` falls. Here N_ACC and N_OE are the cycle counts of the address access time and the output-enable access time.
- R4: Both enables rise together exactly N_OE + 1 cycles after `mem_oe_n` falls, so chip-enable has been low for at least N_ACC cycles.
- R5: On the edge where the enables rise, `rsp_valid` becomes 1 and `rsp_data` holds the byte that was on `mem_data` just before that edge.
- R6: After the enables rise, `mem_ce_n` stays at 1 for at least N_DF + 1 cycles, where N_DF is the float-time count. `req_ready` is 0 for the whole access and the whole float wait.
- R7: While `rsp_valid` is 1 and `rsp_ready` is 0, the response and its data hold, and no new request is accepted. On an edge with `rsp_ready` = 1, the response is dropped.
- R8: `mem_oe_n` is never 0 while `mem_ce_n` is 1. Outside an access, both enables are 1.
- R9: The output-enable access time is 60 ns for grades 150 and 200 and 70 ns for grade 250. The float time is 50, 60 or 70 ns for grades 150, 200 and 250. Every count is ceil(ns × MHz / 1000) + 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Read request can be taken |
| req_addr | input | 12 | Word address to read |
| rsp_valid | output | 1 | Read byte present |
| rsp_ready | input | 1 | Host takes the read byte |
| rsp_data | output | 8 | Read byte |
| mem_addr | output | 12 | Address lines to the EPROM |
| mem_ce_n | output | 1 | Chip-enable to the EPROM, active low |
| mem_oe_n | output | 1 | Output-enable to the EPROM, active low |
| mem_data | input | 8 | Data lines from the EPROM |

## Verification
The bench sweeps addresses across the whole 4096-word range, including the first and last word. The EPROM model returns the correct byte only once chip-enable, output-enable and the address have each been stable for the real access time; before that it returns the inverted byte. A controller that samples too early therefore returns inverted data, and one whose output-enable delay or pulse width is off by a cycle fails the exact edge-distance checks. The bench mixes response stalls of zero to three cycles. A design that accepted a request while holding a response, or that let its data change during a stall, would overwrite the byte or lose the float gap before the next chip-enable fall.

// File: rtl/eprom_rd_pkg.sv
package eprom_rd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_CE_LOW = 3'd1,
    ST_OE_LOW = 3'd2,
    ST_WAIT   = 3'd3,
    ST_SAMPLE = 3'd4,
    ST_FLOAT  = 3'd5
  } rd_state_e;

  // output-enable access time of a speed grade, in ns
  function automatic int oe_access_ns(input int grade_ns);
    return (grade_ns >= 250) ? 70 : 60;
  endfunction

  // outputs-to-float time after an enable rises, in ns
  function automatic int float_ns(input int grade_ns);
    if (grade_ns <= 150) return 50;
    if (grade_ns <= 200) return 60;
    return 70;
  endfunction

  // ceil(ns * MHz / 1000) plus one margin cycle
  function automatic int ns_to_cycles(input int ns, input int mhz);
    return ((ns * mhz) + 999) / 1000 + 1;
  endfunction

  function automatic int acc_cycles(input int grade_ns, input int mhz);
    return ns_to_cycles(grade_ns, mhz);
  endfunction

  function automatic int oe_cycles(input int grade_ns, input int mhz);
    return ns_to_cycles(oe_access_ns(grade_ns), mhz);
  endfunction

  function automatic int float_cycles(input int grade_ns, input int mhz);
    return ns_to_cycles(float_ns(grade_ns), mhz);
  endfunction

  // delay from chip-enable fall to output-enable fall, never under one cycle
  function automatic int oe_delay_cycles(input int grade_ns, input int mhz);
    int d;
    d = acc_cycles(grade_ns, mhz) - oe_cycles(grade_ns, mhz);
    return (d < 1) ? 1 : d;
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/eprom_rd_timer.sv
module eprom_rd_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign done = (cnt_q == '0);

endmodule

// File: rtl/eprom_rd_seq.sv
module eprom_rd_seq
  import eprom_rd_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int CNT_W   = 8,
  parameter int D_OE    = 1,
  parameter int N_OE    = 2,
  parameter int N_DF    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              rsp_busy,
  output logic              req_ready,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              cap_en,
  output logic              tmr_load,
  output logic [CNT_W-1:0]  tmr_val,
  input  logic              tmr_done
);

  localparam logic [CNT_W-1:0] CE_HOLD   = CNT_W'(D_OE - 1);
  localparam logic [CNT_W-1:0] OE_HOLD   = CNT_W'(N_OE - 2);
  localparam logic [CNT_W-1:0] FLT_HOLD  = CNT_W'(N_DF - 1);

  rd_state_e state_q;
  logic      take;

  assign req_ready = (state_q == ST_IDLE) && !rsp_busy;
  assign take      = req_valid && req_ready;
  assign cap_en    = (state_q == ST_SAMPLE);

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (take) begin
          tmr_load = 1'b1;
          tmr_val  = CE_HOLD;
        end
      end
      ST_OE_LOW: begin
        tmr_load = 1'b1;
        tmr_val  = OE_HOLD;
      end
      ST_SAMPLE: begin
        tmr_load = 1'b1;
        tmr_val  = FLT_HOLD;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      mem_ce_n <= 1'b1;
      mem_oe_n <= 1'b1;
      mem_addr <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (take) begin
            state_q  <= ST_CE_LOW;
            mem_ce_n <= 1'b0;
            mem_addr <= req_addr;
          end
        end
        ST_CE_LOW: begin
          if (tmr_done) begin
            state_q  <= ST_OE_LOW;
            mem_oe_n <= 1'b0;
          end
        end
        ST_OE_LOW: state_q <= ST_WAIT;
        ST_WAIT: begin
          if (tmr_done) state_q <= ST_SAMPLE;
        end
        ST_SAMPLE: begin
          state_q  <= ST_FLOAT;
          mem_ce_n <= 1'b1;
          mem_oe_n <= 1'b1;
        end
        ST_FLOAT: begin
          if (tmr_done) state_q <= ST_IDLE;
        end
        default: begin
          state_q  <= ST_IDLE;
          mem_ce_n <= 1'b1;
          mem_oe_n <= 1'b1;
        end
      endcase
    end
  end

endmodule

// File: rtl/eprom_rd_rsp.sv
module eprom_rd_rsp #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic [DATA_W-1:0] mem_data,
  input  logic              rsp_ready,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (cap_en) begin
      rsp_valid <= 1'b1;
      rsp_data  <= mem_data;
    end else if (rsp_valid && rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/eprom_rd_ctrl.sv
module eprom_rd_ctrl
  import eprom_rd_pkg::*;
#(
  parameter int CLK_MHZ  = 100,
  parameter int GRADE_NS = 250,
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  input  logic [DATA_W-1:0] mem_data
);

  localparam int N_ACC = acc_cycles(GRADE_NS, CLK_MHZ);
  localparam int N_OE  = oe_cycles(GRADE_NS, CLK_MHZ);
  localparam int N_DF  = float_cycles(GRADE_NS, CLK_MHZ);
  localparam int D_OE  = oe_delay_cycles(GRADE_NS, CLK_MHZ);
  localparam int CNT_W = $clog2(max3(D_OE, N_OE, N_DF) + 1);

  logic             cap_en;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_done;

  eprom_rd_seq #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W),
    .D_OE   (D_OE),
    .N_OE   (N_OE),
    .N_DF   (N_DF)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .rsp_busy  (rsp_valid),
    .req_ready (req_ready),
    .mem_addr  (mem_addr),
    .mem_ce_n  (mem_ce_n),
    .mem_oe_n  (mem_oe_n),
    .cap_en    (cap_en),
    .tmr_load  (tmr_load),
    .tmr_val   (tmr_val),
    .tmr_done  (tmr_done)
  );

  eprom_rd_timer #(
    .CNT_W (CNT_W)
  ) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .done     (tmr_done)
  );

  eprom_rd_rsp #(
    .DATA_W (DATA_W)
  ) u_rsp (
    .clk       (clk),
    .rst_n     (rst_n),
    .cap_en    (cap_en),
    .mem_data  (mem_data),
    .rsp_ready (rsp_ready),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data)
  );

endmodule

// File: rtl/eprom_rd_chk.sv
module eprom_rd_chk
  import eprom_rd_pkg::*;
#(
  parameter int CLK_MHZ  = 100,
  parameter int GRADE_NS = 250,
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DATA_W-1:0] rsp_data,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ce_n,
  input logic              mem_oe_n
);

  localparam int N_DF = float_cycles(GRADE_NS, CLK_MHZ);

  logic [15:0] hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt <= 16'hFFFF;
    end else if (!mem_ce_n) begin
      hi_cnt <= '0;
    end else if (hi_cnt != 16'hFFFF) begin
      hi_cnt <= hi_cnt + 16'd1;
    end
  end

  assert_oe_inside_ce_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> !mem_ce_n);

  assert_addr_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

  assert_rsp_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

  assert_idle_when_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_ce_n && !rsp_valid));

  assert_rsp_with_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) |-> $rose(mem_ce_n));

  assert_float_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_ce_n) |-> (hi_cnt >= 16'(N_DF + 1)));

endmodule

bind eprom_rd_ctrl eprom_rd_chk #(
  .CLK_MHZ  (CLK_MHZ),
  .GRADE_NS (GRADE_NS),
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_data  (rsp_data),
  .mem_addr  (mem_addr),
  .mem_ce_n  (mem_ce_n),
  .mem_oe_n  (mem_oe_n)
);

// File: tb/test_eprom_rd_ctrl.sv
module test_eprom_rd_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int MHZ        = 100;
  localparam int GRADE      = 250;
  localparam int T_OE_NS    = 70;   // R9: grade 250
  localparam int T_DF_NS    = 70;   // R9: grade 250
  localparam int N_ACC      = (GRADE * MHZ + 999) / 1000 + 1;
  localparam int N_OE       = (T_OE_NS * MHZ + 999) / 1000 + 1;
  localparam int N_DF       = (T_DF_NS * MHZ + 999) / 1000 + 1;
  localparam int D_OE       = (N_ACC - N_OE < 1) ? 1 : (N_ACC - N_OE);
  localparam int ACC_MIN    = (GRADE + CLK_PERIOD - 1) / CLK_PERIOD;
  localparam int OE_MIN     = (T_OE_NS + CLK_PERIOD - 1) / CLK_PERIOD;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [11:0] req_addr = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [7:0]  rsp_data;
  logic [11:0] mem_addr;
  logic        mem_ce_n;
  logic        mem_oe_n;
  logic [7:0]  mem_data;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  logic [11:0] exp_addr = '0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  eprom_rd_ctrl #(.CLK_MHZ(MHZ), .GRADE_NS(GRADE)) i_eprom_rd_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_data(rsp_data), .mem_addr(mem_addr), .mem_ce_n(mem_ce_n),
    .mem_oe_n(mem_oe_n), .mem_data(mem_data)
  );

  function automatic logic [7:0] pat(input logic [11:0] a);
    return a[7:0] ^ {a[11:8], a[11:8]} ^ 8'hA5;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // EPROM model: right byte only after the real access times
  int ce_age = 0, oe_age = 0, addr_age = 0;
  logic [11:0] last_addr = '0;
  always @(negedge clk) begin
    ce_age   <= mem_ce_n ? 0 : ce_age + 1;
    oe_age   <= mem_oe_n ? 0 : oe_age + 1;
    addr_age <= (mem_addr != last_addr) ? 0 : addr_age + 1;
    last_addr <= mem_addr;
  end
  always_comb begin
    if (!mem_ce_n && !mem_oe_n && ce_age >= ACC_MIN && oe_age >= OE_MIN && addr_age >= ACC_MIN)
      mem_data = pat(mem_addr);
    else
      mem_data = ~pat(mem_addr);
  end

  // edge monitor
  int t_ce = 0, t_oe = 0, t_rise = -1000;
  logic prev_ce = 1'b1, prev_oe = 1'b1;
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (prev_ce && !mem_ce_n) begin
        t_ce = cyc;
        check(cyc - t_rise >= N_DF + 1, "R6 float gap", cyc - t_rise, N_DF + 1);
        check(mem_addr == exp_addr, "R2 address driven", int'(mem_addr), int'(exp_addr));
      end
      if (prev_oe && !mem_oe_n) begin
        t_oe = cyc;
        check(cyc - t_ce == D_OE, "R3 oe delay (R9 counts)", cyc - t_ce, D_OE);
      end
      if (!prev_ce && mem_ce_n) begin
        t_rise = cyc;
        check(cyc - t_oe == N_OE + 1, "R4 oe width (R9 counts)", cyc - t_oe, N_OE + 1);
        check(cyc - t_ce >= N_ACC, "R4 ce width", cyc - t_ce, N_ACC);
        check(mem_oe_n == 1'b1, "R8 oe released with ce", int'(mem_oe_n), 1);
        check(rsp_valid == 1'b1, "R5 response valid", int'(rsp_valid), 1);
        check(rsp_data == pat(exp_addr), "R5 data", int'(rsp_data), int'(pat(exp_addr)));
        check(mem_addr == exp_addr, "R2 address held", int'(mem_addr), int'(exp_addr));
      end
      if (!mem_oe_n && mem_ce_n)
        check(1'b0, "R8 oe without ce", int'(mem_oe_n), 1);
      if (!mem_ce_n && req_ready)
        check(1'b0, "R6 ready while busy", int'(req_ready), 0);
    end
    prev_ce = mem_ce_n;
    prev_oe = mem_oe_n;
  end

  task automatic do_read(input logic [11:0] a, input int hold);
    bit acc;
    exp_addr  = a;
    rsp_ready = (hold == 0);
    req_addr  = a;
    req_valid = 1'b1;
    do begin
      @(negedge clk);
      acc = req_ready;
      @(posedge clk);
    end while (!acc);
    @(negedge clk);
    req_valid = 1'b0;
    req_addr  = ~a;
    while (!rsp_valid) @(negedge clk);
    if (hold == 0) begin
      @(negedge clk);
      check(rsp_valid == 1'b0, "R7 consumed at once", int'(rsp_valid), 0);
      rsp_ready = 1'b0;
    end else begin
      for (int k = 0; k < hold; k++) begin
        check(rsp_valid && rsp_data == pat(a), "R7 held under stall", int'(rsp_data), int'(pat(a)));
        check(req_ready == 1'b0, "R7 no accept while held", int'(req_ready), 0);
        @(negedge clk);
      end
      rsp_ready = 1'b1;
      @(negedge clk);
      rsp_ready = 1'b0;
      check(rsp_valid == 1'b0, "R7 dropped after ready", int'(rsp_valid), 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(mem_ce_n && mem_oe_n, "R1 enables in reset", int'({mem_ce_n, mem_oe_n}), 3);
    rst_n = 1'b1;
    @(negedge clk);
    check(mem_ce_n && mem_oe_n, "R1 enables after reset", int'({mem_ce_n, mem_oe_n}), 3);
    check(rsp_valid == 1'b0, "R1 no response", int'(rsp_valid), 0);
    check(req_ready == 1'b1, "R1 ready", int'(req_ready), 1);
    for (int i = 0; i <= 4095; i += 5) begin
      do_read(12'(i), i % 4);
      if (i % 40 == 0) begin
        repeat (3) @(negedge clk);
        check(mem_ce_n && mem_oe_n, "R8 standby when idle", int'({mem_ce_n, mem_oe_n}), 3);
      end
    end
    do_read(12'hFFF, 0);
    do_read(12'h000, 3);
    do_read(12'hA5A, 1);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog actual=%0d expected=%0d", 190000, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule